// File: doc/BRIEF.md
# Bus Slave Access Port with Byte-Strobed Local Storage

This block is the slave end of a pipelined on-chip bus. It watches the shared address and control lines. When a transfer for this slave is accepted, it records the word address, the direction and whether the access is legal. In the next cycle, the data phase, it either writes the strobed bytes of the write data into a small local register array or returns the addressed word on the read data lines. It also drives the slave's ready-out and response back onto the bus.

The adapter has no wait states: ready-out is high in every cycle. A transfer counts only when three conditions hold in the address phase: the slave is selected, the global ready is high, and the upper bit of the transfer type is set. Any other combination leaves the storage untouched and answers OKAY. An access is answered with ERROR in its data phase if it points past the local storage, asks for more bytes than the bus carries, or is not aligned to its own size. An access answered with ERROR changes nothing.

Top module: `ahb_mem_slave_port`

## Requirements
- R1: An address phase is accepted only when `sel_i`=1, `rdy_in_i`=1 and `xfer_i[1]`=1 (NONSEQ=2'b10 or SEQ=2'b11). In every other cycle, including IDLE=2'b00, BUSY=2'b01, a deselected slave or a low global ready, storage and outputs behave as if no transfer occurred.
- R2: The word index `addr_i[ADDR_W-1:2]` is captured on an accepted address phase, and the following data phase reads or writes that word.
- R3: An accepted phase with `wr_i`=1 raises the internal write enable for one cycle, and with `wr_i`=0 raises the read enable. The two are never high together, so a read never modifies storage whatever the write data and strobes are.
- R4: While `rst_n` is low, the enables, the captured phase state and every storage word are cleared to zero.
- R5: `wdata_i` and `bstrb_i` are sampled in the data phase, one cycle after the accepted write address phase. Strobe bit b updates only byte lane `[8b+7:8b]`.
- R6: During the data phase of an accepted legal read, `rdata_o` equals the stored word. In every other cycle `rdata_o` is zero.
- R7: `resp_o` is OKAY (2'b00) in every cycle that is not the data phase of an erroneous access.
- R8: A word index of DEPTH or above gives `resp_o`=ERROR (2'b01) in the data phase, writes nothing and returns zero read data.
- R9: A size code above 2 (wider than the 32-bit bus), or an address whose low `size` bits are not zero, gives ERROR in the data phase and writes nothing.
- R10: `rdy_out_o` is high in every cycle, including reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| sel_i | input | 1 | Slave select from the address decoder |
| rdy_in_i | input | 1 | Global ready of the bus |
| xfer_i | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the address phase |
| size_i | input | 3 | log2 of the access size in bytes |
| burst_i | input | 3 | Burst kind (accepted, no effect on this slave) |
| wdata_i | input | DATA_W | Write data, data phase |
| bstrb_i | input | DATA_W/8 | Byte strobes, data phase |
| rdata_o | output | DATA_W | Read data, data phase |
| rdy_out_o | output | 1 | Slave ready-out |
| resp_o | output | 2 | Response: 0 OKAY, 1 ERROR |

## Verification
The assertions assume that the bus keeps `sel_i`, `xfer_i`, `wr_i`, `addr_i` and `size_i` at known values at every clock edge after reset. They also assume that the global ready reflects this slave's ready in its own data phases. The stimulus always drives every input to a defined value. It releases the address lines to IDLE in each data phase and never holds the global ready low while one of this slave's data phases is in flight. Within these limits, the sweeps cover every word index, every strobe pattern, each of the size codes it uses, and addresses both inside and outside the storage.

// File: rtl/slvport_pkg.sv
package slvport_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY  = 2'd0,
    RESP_ERROR = 2'd1
  } resp_e;
endpackage

// File: rtl/slvport_addr_phase.sv
// Address-phase qualifier: accepts a transfer, checks its legality and
// registers direction, word index and error for the data phase.
module slvport_addr_phase #(
  parameter int ADDR_W = 12,
  parameter int BYTES  = 4,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_i,
  input  logic                     rdy_in_i,
  input  logic [1:0]               xfer_i,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [2:0]               size_i,
  output logic                     wr_en_o,
  output logic                     rd_en_o,
  output logic                     err_o,
  output logic [$clog2(DEPTH)-1:0] idx_o
);
  localparam int OFS   = $clog2(BYTES);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int WRD_W = ADDR_W - OFS;

  logic             accept;
  logic [WRD_W-1:0] word;
  logic [OFS-1:0]   mask;
  logic             bad;
  logic             unused_seq;

  assign unused_seq = xfer_i[0];
  assign accept     = sel_i & rdy_in_i & xfer_i[1];
  assign word       = addr_i[ADDR_W-1:OFS];

  // Low-address bits that must be zero for an access of the given size.
  always_comb begin
    for (int k = 0; k < OFS; k++) begin
      mask[k] = (size_i > 3'(k));
    end
  end

  assign bad = (word >= WRD_W'(DEPTH))
             | (size_i > 3'(OFS))
             | (|(addr_i[OFS-1:0] & mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o <= 1'b0;
      rd_en_o <= 1'b0;
      err_o   <= 1'b0;
      idx_o   <= '0;
    end else begin
      wr_en_o <= accept & wr_i;
      rd_en_o <= accept & ~wr_i;
      err_o   <= accept & bad;
      if (accept) begin
        idx_o <= word[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/slvport_store.sv
// Local register array with byte-lane write strobes.
module slvport_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic                     re_i,
  input  logic [$clog2(DEPTH)-1:0] idx_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [DATA_W/8-1:0]      bstrb_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rdy_o
);
  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] rd_word [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              hit;
    assign hit = we_i && (idx_i == w[$clog2(DEPTH)-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (hit) begin
        for (int b = 0; b < BYTES; b++) begin
          if (bstrb_i[b]) begin
            word_q[b*8 +: 8] <= wdata_i[b*8 +: 8];
          end
        end
      end
    end
    assign rd_word[w] = word_q;
  end

  assign rdata_o = re_i ? rd_word[idx_i] : '0;
  assign rdy_o   = 1'b1;
endmodule

// File: rtl/ahb_mem_slave_port.sv
module ahb_mem_slave_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_i,
  input  logic                rdy_in_i,
  input  logic [1:0]          xfer_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2:0]          size_i,
  input  logic [2:0]          burst_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] bstrb_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rdy_out_o,
  output logic [1:0]          resp_o
);
  import slvport_pkg::*;

  localparam int BYTES = DATA_W / 8;
  localparam int IDX_W = $clog2(DEPTH);

  logic             wr_en;
  logic             rd_en;
  logic             err_q;
  logic [IDX_W-1:0] idx_q;
  logic             unused_burst;
  resp_e            resp;

  assign unused_burst = ^burst_i;

  slvport_addr_phase #(
    .ADDR_W(ADDR_W), .BYTES(BYTES), .DEPTH(DEPTH)
  ) u_aph (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (sel_i),
    .rdy_in_i (rdy_in_i),
    .xfer_i   (xfer_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .size_i   (size_i),
    .wr_en_o  (wr_en),
    .rd_en_o  (rd_en),
    .err_o    (err_q),
    .idx_o    (idx_q)
  );

  slvport_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_en & ~err_q),
    .re_i    (rd_en & ~err_q),
    .idx_i   (idx_q),
    .wdata_i (wdata_i),
    .bstrb_i (bstrb_i),
    .rdata_o (rdata_o),
    .rdy_o   (rdy_out_o)
  );

  assign resp   = err_q ? RESP_ERROR : RESP_OKAY;
  assign resp_o = resp;
endmodule

// File: rtl/ahb_mem_slave_port_chk.sv
module ahb_mem_slave_port_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sel_i,
  input logic                     rdy_in_i,
  input logic [1:0]               xfer_i,
  input logic                     wr_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [DATA_W-1:0]        rdata_o,
  input logic                     rdy_out_o,
  input logic [1:0]               resp_o,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic [$clog2(DEPTH)-1:0] idx_q
);
  localparam int OFS   = $clog2(DATA_W / 8);
  localparam int IDX_W = $clog2(DEPTH);

  logic acc;
  assign acc = sel_i && rdy_in_i && xfer_i[1];

  assert_write_detect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wr_i |=> wr_en && !rd_en);

  assert_no_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !wr_en && !rd_en && resp_o == 2'd0);

  assert_index_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> idx_q == $past(addr_i[OFS+IDX_W-1:OFS]));

  assert_enables_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

  assert_rdata_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata_o == '0);

  assert_range_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (addr_i[ADDR_W-1:OFS] >= (ADDR_W-OFS)'(DEPTH)) |=> resp_o == 2'd1);

  assert_ready_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_out_o);
endmodule

bind ahb_mem_slave_port ahb_mem_slave_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_i     (sel_i),
  .rdy_in_i  (rdy_in_i),
  .xfer_i    (xfer_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .rdy_out_o (rdy_out_o),
  .resp_o    (resp_o),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .idx_q     (idx_q)
);

// File: tb/ahb_mem_slave_port_test.sv
module ahb_mem_slave_port_test;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sel, rdy_in, wr;
  logic [1:0]        xfer;
  logic [ADDR_W-1:0] addr;
  logic [2:0]        size, burst;
  logic [31:0]       wdata;
  logic [3:0]        bstrb;
  logic [31:0]       rdata;
  logic              rdy_out;
  logic [1:0]        resp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] model [DEPTH];

  always #10 clk = ~clk;

  ahb_mem_slave_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .rdy_in_i(rdy_in), .xfer_i(xfer),
    .wr_i(wr), .addr_i(addr), .size_i(size), .burst_i(burst), .wdata_i(wdata),
    .bstrb_i(bstrb), .rdata_o(rdata), .rdy_out_o(rdy_out), .resp_o(resp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One address phase followed by one data phase, with expected outputs
  // derived from the requirements and a byte-wise storage model.
  task automatic access(input string req, input logic s, input logic r,
                        input logic [1:0] t, input logic w, input logic [11:0] a,
                        input logic [2:0] sz, input logic [31:0] d, input logic [3:0] st);
    logic acc, err;
    int idx;
    logic [31:0] exp_rd;
    acc = s && r && t[1];
    idx = int'(a >> 2);
    err = acc && ((idx >= DEPTH) || (sz > 3'd2) ||
                  (sz <= 3'd2 && ((a & ((12'd1 << sz) - 12'd1)) != 12'd0)));
    exp_rd = (acc && !w && !err) ? model[idx] : 32'd0;
    @(negedge clk);
    sel = s; rdy_in = r; xfer = t; wr = w; addr = a; size = sz; burst = 3'd1;
    wdata = 32'hDEAD_0000; bstrb = 4'h0;
    @(negedge clk);
    sel = 1'b0; rdy_in = 1'b1; xfer = 2'b00; wr = 1'b0; addr = '0; size = 3'd2;
    wdata = d; bstrb = st;
    #2;
    check({req, " rdata"}, rdata, exp_rd);
    check({req, " resp"}, {30'd0, resp}, err ? 32'd1 : 32'd0);
    check("R10 ready-out", {31'd0, rdy_out}, 32'd1);
    if (acc && w && !err) begin
      for (int b = 0; b < 4; b++) begin
        if (st[b]) model[idx][b*8 +: 8] = d[b*8 +: 8];
      end
    end
  endtask

  task automatic rd_word(input string req, input int i);
    access(req, 1'b1, 1'b1, 2'b10, 1'b0, 12'(i * 4), 3'd2, 32'hFFFF_FFFF, 4'hF);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 32'd0;
    rst_n = 1'b0; sel = 1'b0; rdy_in = 1'b1; xfer = 2'b00; wr = 1'b0;
    addr = '0; size = 3'd2; burst = 3'd0; wdata = '0; bstrb = '0;
    repeat (3) @(negedge clk);
    check("R10 ready in reset", {31'd0, rdy_out}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check("R4 rdata after reset", rdata, 32'd0);
    check("R7 resp after reset", {30'd0, resp}, 32'd0);

    // R4 / R6: every word reads zero after reset
    for (int i = 0; i < DEPTH; i++) rd_word("R4 cleared word", i);

    // R2 / R5 / R6: full-strobe write sweep, then read-back sweep
    for (int i = 0; i < DEPTH; i++)
      access("R5 full write", 1'b1, 1'b1, (i % 2 == 0) ? 2'b10 : 2'b11, 1'b1,
             12'(i * 4), 3'd2, 32'h1000_0001 * (i + 1) ^ 32'hC3C3_0000, 4'hF);
    for (int i = 0; i < DEPTH; i++) rd_word("R2 R6 read-back", i);

    // R5: every strobe pattern on word 5
    for (int s = 0; s < 16; s++) begin
      access("R5 strobed write", 1'b1, 1'b1, 2'b10, 1'b1, 12'd20, 3'd2,
             32'h0101_0101 * (s + 7), 4'(s));
      rd_word("R5 strobe result", 5);
    end

    // R1: rejected address phases leave word 2 unchanged
    access("R1 deselected", 1'b0, 1'b1, 2'b10, 1'b1, 12'd8, 3'd2, 32'h1111_1111, 4'hF);
    rd_word("R1 after deselected", 2);
    access("R1 busy", 1'b1, 1'b1, 2'b01, 1'b1, 12'd8, 3'd2, 32'h2222_2222, 4'hF);
    rd_word("R1 after busy", 2);
    access("R1 idle", 1'b1, 1'b1, 2'b00, 1'b1, 12'd8, 3'd2, 32'h3333_3333, 4'hF);
    rd_word("R1 after idle", 2);
    access("R1 ready low", 1'b1, 1'b0, 2'b10, 1'b1, 12'd8, 3'd2, 32'h4444_4444, 4'hF);
    rd_word("R1 after ready low", 2);

    // R3: a read with live write data and strobes does not modify storage
    access("R3 read with strobes", 1'b1, 1'b1, 2'b11, 1'b0, 12'd8, 3'd2, 32'h5555_5555, 4'hF);
    rd_word("R3 after read", 2);

    // R8: outside local storage
    access("R8 write past end", 1'b1, 1'b1, 2'b10, 1'b1, 12'(DEPTH * 4), 3'd2, 32'h6666_6666, 4'hF);
    access("R8 write top", 1'b1, 1'b1, 2'b10, 1'b1, 12'hFFC, 3'd2, 32'h7777_7777, 4'hF);
    access("R8 read past end", 1'b1, 1'b1, 2'b10, 1'b0, 12'(DEPTH * 4), 3'd2, 32'h0, 4'h0);
    rd_word("R8 word0 unchanged", 0);

    // R9: size and alignment
    access("R9 size too wide", 1'b1, 1'b1, 2'b10, 1'b1, 12'd0, 3'd3, 32'h8888_8888, 4'hF);
    access("R9 word misaligned", 1'b1, 1'b1, 2'b10, 1'b1, 12'd1, 3'd2, 32'h9999_9999, 4'hF);
    access("R9 half misaligned", 1'b1, 1'b1, 2'b10, 1'b1, 12'd3, 3'd1, 32'hAAAA_AAAA, 4'hC);
    rd_word("R9 word0 unchanged", 0);
    access("R9 half aligned", 1'b1, 1'b1, 2'b10, 1'b1, 12'd6, 3'd1, 32'hBEEF_0000, 4'hC);
    access("R9 byte any", 1'b1, 1'b1, 2'b10, 1'b1, 12'd7, 3'd0, 32'h5A00_0000, 4'h8);
    rd_word("R9 word1 result", 1);

    // R7: idle cycle after all traffic
    @(negedge clk); #2;
    check("R7 idle resp", {30'd0, resp}, 32'd0);
    check("R6 idle rdata", rdata, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule